// File: doc/BRIEF.md
# Flat-Panel Pixel Output Formatter

This block sits between a display-link receiver and a flat-panel connector. Every input clock it takes one pixel of three colour channels, a data-enable flag, horizontal and vertical sync, and three general-purpose control bits. It registers them onto an even pixel bus, an odd pixel bus and a set of registered enable, sync and control outputs. It also produces an output clock whose edges fall midway between output updates.

Static configuration pins control three things. The first selects single-pixel or paired-pixel output. In paired mode two consecutive pixels leave together at half the input rate. The second selects a free-running or an enable-gated output clock; the gated clock suits passive-matrix panels. The third selects which output-clock edge the panel should sample on. A power-down pin silences every output except control bit 1.

The input stream has no back-pressure. The block accepts a sample on every clock edge and has no valid/ready pair. The upstream receiver must present a new sample each clock.

Top module: `panel_out_fmt`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it falls, `q_even`, `q_odd`, `de_out`, `hs_out`, `vs_out` and `ctl_out` are all zero, and the pairing state returns to "next pixel is first".
- R2: With `cfg_two_pix`=0, each edge updates the outputs from that cycle's inputs. When `de_in`=1, `q_even` takes `pix_in` and `q_odd` is zero.
- R3: When an update samples `de_in`=0, both pixel buses become zero. `hs_out`, `vs_out` and `ctl_out` take the input values.
- R4: `de_out` copies `de_in` at each update, so it is high only for active-display samples.
- R5: With `cfg_two_pix`=1, the first pixel of a pair is driven on `q_even` and the second on `q_odd`. Both appear after the edge that accepts the second pixel, and they hold until the next pair completes.
- R6: In paired mode, a rising `de_in` always starts a new pair. A pixel left unpaired when `de_in` falls is dropped.
- R7: With `cfg_gate_clk`=0 the output clock runs continuously. In single mode with `cfg_rise_pol`=1, `oclk` is low while `clk` is high and high while `clk` is low; with `cfg_rise_pol`=0, `oclk` equals `clk`. In paired mode with `cfg_rise_pol`=1, `oclk` is low for the input period after an update and high for the next; with `cfg_rise_pol`=0 it is inverted.
- R8: With `cfg_gate_clk`=1, `oclk` is held low whenever `de_out` is low, and it toggles as in R7 while `de_out` is high.
- R9: While `pwr_dn`=1, `oclk`, the pixel buses, `de_out`, `hs_out`, `vs_out` and control bits 2 and 3 (`ctl_out[2:1]`) are low. Control bit 1 (`ctl_out[0]`) keeps following `ctl_in[0]`.
- R10: In paired mode the outputs update on every other edge, also during blanking; no two consecutive edges both update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 3*CW | Incoming pixel, red in the top byte, then green, then blue |
| de_in | input | 1 | Active-display flag |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| ctl_in | input | NCTL | Control bits; bit 0 is control 1 |
| cfg_two_pix | input | 1 | 1 = paired pixels per output clock |
| cfg_gate_clk | input | 1 | 1 = output clock held low during blanking |
| cfg_rise_pol | input | 1 | 1 = panel samples on rising `oclk` |
| pwr_dn | input | 1 | Power-down |
| q_even | output | 3*CW | Even (first) pixel bus |
| q_odd | output | 3*CW | Odd (second) pixel bus |
| oclk | output | 1 | Output data clock |
| de_out | output | 1 | Registered data enable |
| hs_out | output | 1 | Registered horizontal sync |
| vs_out | output | 1 | Registered vertical sync |
| ctl_out | output | NCTL | Registered control bits |

## Verification
The assertions assume that every input is stable around the rising `clk` edge. They also assume that a configuration pin, once changed, is still in place on the edge after the change, because several properties use `$past` of the mode. The bench drives all inputs on the falling edge and changes the configuration only between steps. It therefore never moves a mode pin within the one-cycle window a property looks across. Output clock levels are sampled one nanosecond into each half period, so the combinational path from `clk` to `oclk` has settled.

// File: rtl/pof_pkg.sv
package pof_pkg;
  // Position of the next incoming pixel within a pair.
  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;

  localparam int unsigned DEF_CW   = 8;
  localparam int unsigned DEF_NCTL = 3;
endpackage

// File: rtl/pof_pair_ctl.sv
module pof_pair_ctl
  import pof_pkg::*;
#(
  parameter int unsigned PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_pix,
  input  logic          de_in,
  input  logic [PW-1:0] pix_in,
  output logic          emit,
  output logic [PW-1:0] hold
);
  slot_e slot_q;
  logic  de_prev_q;
  logic  de_rise;
  slot_e eff_slot;

  assign de_rise  = de_in & ~de_prev_q;
  assign eff_slot = de_rise ? SLOT_FIRST : slot_q;
  assign emit     = two_pix ? (eff_slot == SLOT_SECOND) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= SLOT_FIRST;
      de_prev_q <= 1'b0;
      hold      <= '0;
    end else begin
      de_prev_q <= de_in;
      if (two_pix)
        slot_q <= (eff_slot == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
      else
        slot_q <= SLOT_FIRST;
      if (eff_slot == SLOT_FIRST)
        hold <= pix_in;
    end
  end

  // R10: paired mode never updates on two consecutive edges
  a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (two_pix && emit) |=> !(two_pix && emit));

endmodule

// File: rtl/pof_out_reg.sv
module pof_out_reg #(
  parameter int unsigned PW   = 24,
  parameter int unsigned NCTL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emit,
  input  logic            two_pix,
  input  logic            pwr_dn,
  input  logic            de_in,
  input  logic            hs_in,
  input  logic            vs_in,
  input  logic [NCTL-1:0] ctl_in,
  input  logic [PW-1:0]   pix_in,
  input  logic [PW-1:0]   hold,
  output logic [PW-1:0]   q_even,
  output logic [PW-1:0]   q_odd,
  output logic            de_o,
  output logic            hs_o,
  output logic            vs_o,
  output logic [NCTL-1:0] ctl_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_even <= '0;
      q_odd  <= '0;
      de_o   <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      ctl_o  <= '0;
    end else if (pwr_dn) begin
      q_even <= '0;
      q_odd  <= '0;
      de_o   <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      ctl_o[NCTL-1:1] <= '0;
      if (emit)
        ctl_o[0] <= ctl_in[0];
    end else if (emit) begin
      de_o  <= de_in;
      hs_o  <= hs_in;
      vs_o  <= vs_in;
      ctl_o <= ctl_in;
      if (de_in) begin
        q_even <= two_pix ? hold : pix_in;
        q_odd  <= two_pix ? pix_in : '0;
      end else begin
        q_even <= '0;
        q_odd  <= '0;
      end
    end
  end

  // R3: a blanking update clears both pixel buses
  a_r3_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !de_in && !pwr_dn) |=> (q_even == '0 && q_odd == '0));

  // R2: single-pixel mode leaves the odd bus at zero
  a_r2_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_pix && emit) |=> (q_odd == '0));

  // R5: the second pixel of a pair lands on the odd bus
  a_r5_odd_second: assert property (@(posedge clk) disable iff (!rst_n)
    (two_pix && emit && de_in && !pwr_dn) |=> (q_odd == $past(pix_in)));

  // R9: power-down forces the enable, sync and even bus low
  a_r9_pd_forced: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!de_o && !hs_o && !vs_o && q_even == '0));

endmodule

// File: rtl/pof_clk_gen.sv
module pof_clk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic two_pix,
  input  logic gate_clk,
  input  logic rise_pol,
  input  logic pwr_dn,
  input  logic emit,
  input  logic de_o,
  output logic oclk
);
  logic half_q;
  logic phase;

  // Low for the period after an update, high for the one before the next.
  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~emit;
  end

  assign phase = two_pix ? half_q : ~clk;

  always_comb begin
    if (pwr_dn || (gate_clk && !de_o)) oclk = 1'b0;
    else                                oclk = rise_pol ? phase : ~phase;
  end

endmodule

// File: rtl/panel_out_fmt.sv
module panel_out_fmt
  import pof_pkg::*;
#(
  parameter int unsigned CW   = DEF_CW,
  parameter int unsigned NCTL = DEF_NCTL,
  localparam int unsigned PW  = 3 * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   pix_in,
  input  logic            de_in,
  input  logic            hs_in,
  input  logic            vs_in,
  input  logic [NCTL-1:0] ctl_in,
  input  logic            cfg_two_pix,
  input  logic            cfg_gate_clk,
  input  logic            cfg_rise_pol,
  input  logic            pwr_dn,
  output logic [PW-1:0]   q_even,
  output logic [PW-1:0]   q_odd,
  output logic            oclk,
  output logic            de_out,
  output logic            hs_out,
  output logic            vs_out,
  output logic [NCTL-1:0] ctl_out
);
  logic          emit;
  logic [PW-1:0] hold;

  pof_pair_ctl #(.PW(PW)) u_pair (
    .clk     (clk),
    .rst_n   (rst_n),
    .two_pix (cfg_two_pix),
    .de_in   (de_in),
    .pix_in  (pix_in),
    .emit    (emit),
    .hold    (hold)
  );

  pof_out_reg #(.PW(PW), .NCTL(NCTL)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .emit    (emit),
    .two_pix (cfg_two_pix),
    .pwr_dn  (pwr_dn),
    .de_in   (de_in),
    .hs_in   (hs_in),
    .vs_in   (vs_in),
    .ctl_in  (ctl_in),
    .pix_in  (pix_in),
    .hold    (hold),
    .q_even  (q_even),
    .q_odd   (q_odd),
    .de_o    (de_out),
    .hs_o    (hs_out),
    .vs_o    (vs_out),
    .ctl_o   (ctl_out)
  );

  pof_clk_gen u_ck (
    .clk      (clk),
    .rst_n    (rst_n),
    .two_pix  (cfg_two_pix),
    .gate_clk (cfg_gate_clk),
    .rise_pol (cfg_rise_pol),
    .pwr_dn   (pwr_dn),
    .emit     (emit),
    .de_o     (de_out),
    .oclk     (oclk)
  );

  // R1: the first edge with reset low clears the registered outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (de_out == 1'b0 && q_even == '0 && q_odd == '0 && ctl_out == '0));

endmodule

// File: tb/panel_out_fmt_tb_top.sv
`timescale 1ns/1ps
module panel_out_fmt_tb_top;
  localparam int CW = 8;
  localparam int NC = 3;
  localparam int PW = 3 * CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] pix_in;
  logic          de_in, hs_in, vs_in;
  logic [NC-1:0] ctl_in;
  logic          cfg_two_pix, cfg_gate_clk, cfg_rise_pol, pwr_dn;
  logic [PW-1:0] q_even, q_odd;
  logic          oclk, de_out, hs_out, vs_out;
  logic [NC-1:0] ctl_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  panel_out_fmt #(.CW(CW), .NCTL(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .de_in(de_in), .hs_in(hs_in),
    .vs_in(vs_in), .ctl_in(ctl_in), .cfg_two_pix(cfg_two_pix),
    .cfg_gate_clk(cfg_gate_clk), .cfg_rise_pol(cfg_rise_pol), .pwr_dn(pwr_dn),
    .q_even(q_even), .q_odd(q_odd), .oclk(oclk), .de_out(de_out),
    .hs_out(hs_out), .vs_out(vs_out), .ctl_out(ctl_out)
  );

  typedef struct packed {
    logic          de;
    logic          hs;
    logic          vs;
    logic [NC-1:0] ctl;
    logic [PW-1:0] pix;
    logic [PW-1:0] exp_even;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 3'b000, 24'hFF0000, 24'hFF0000},
    '{1'b1, 1'b0, 1'b0, 3'b101, 24'h00FF00, 24'h00FF00},
    '{1'b1, 1'b0, 1'b0, 3'b010, 24'h123456, 24'h123456},
    '{1'b0, 1'b1, 1'b0, 3'b111, 24'hABCDEF, 24'h000000},
    '{1'b0, 1'b1, 1'b1, 3'b001, 24'h777777, 24'h000000},
    '{1'b1, 1'b0, 1'b1, 3'b100, 24'h0000FF, 24'h0000FF}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic de, input logic hs, input logic vs,
                      input logic [NC-1:0] ctl, input logic [PW-1:0] pix);
    @(negedge clk);
    de_in = de; hs_in = hs; vs_in = vs; ctl_in = ctl; pix_in = pix;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_in = '0; de_in = 0; hs_in = 0; vs_in = 0; ctl_in = '0;
    cfg_two_pix = 0; cfg_gate_clk = 0; cfg_rise_pol = 1; pwr_dn = 0;
    step(1, 1, 1, 3'b111, 24'h5A5A5A);
    step(1, 1, 1, 3'b111, 24'h5A5A5A);
    // R1: reset holds every registered output at zero
    check("R1 reset even", {40'd0, q_even}, 64'd0);
    check("R1 reset de/hs/vs/ctl", {58'd0, de_out, hs_out, vs_out, ctl_out}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: single-pixel mode, R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].de, TBL[i].hs, TBL[i].vs, TBL[i].ctl, TBL[i].pix);
      check("R2 even bus", {40'd0, q_even}, {40'd0, TBL[i].exp_even});
      check("R2 odd zero", {40'd0, q_odd}, 64'd0);
      check("R4 de follows", {63'd0, de_out}, {63'd0, TBL[i].de});
      check("R3 sync/ctl", {59'd0, hs_out, vs_out, ctl_out},
            {59'd0, TBL[i].hs, TBL[i].vs, TBL[i].ctl});
    end

    // R7: continuous clock, rising polarity, single mode
    check("R7 oclk low in clk high", {63'd0, oclk}, 64'd0);
    @(negedge clk); #1;
    check("R7 oclk high in clk low", {63'd0, oclk}, 64'd1);

    // Paired mode, R5 R6 R10
    cfg_two_pix = 1;
    step(0, 0, 0, 3'b000, 24'h0);
    step(1, 0, 0, 3'b000, 24'hA00001);
    step(1, 0, 0, 3'b000, 24'hA00002);
    check("R5 pair even", {40'd0, q_even}, {40'd0, 24'hA00001});
    check("R5 pair odd", {40'd0, q_odd}, {40'd0, 24'hA00002});
    check("R7 paired oclk low after update", {63'd0, oclk}, 64'd0);
    step(1, 0, 0, 3'b000, 24'hA00003);
    check("R5 hold even", {40'd0, q_even}, {40'd0, 24'hA00001});
    check("R5 hold odd", {40'd0, q_odd}, {40'd0, 24'hA00002});
    check("R7 paired oclk high mid", {63'd0, oclk}, 64'd1);
    step(0, 0, 0, 3'b000, 24'hBADBAD);
    check("R6 unpaired dropped", {40'd0, q_even}, 64'd0);
    check("R4 de low paired", {63'd0, de_out}, 64'd0);
    step(0, 0, 0, 3'b000, 24'h0);
    step(1, 0, 0, 3'b000, 24'hC00001);
    check("R6 no update on rise", {40'd0, q_even}, 64'd0);
    step(1, 0, 0, 3'b000, 24'hC00002);
    check("R6 restart even", {40'd0, q_even}, {40'd0, 24'hC00001});
    check("R6 restart odd", {40'd0, q_odd}, {40'd0, 24'hC00002});
    step(0, 1, 0, 3'b000, 24'h0);
    check("R10 skipped edge", {63'd0, hs_out}, 64'd0);
    step(0, 1, 0, 3'b000, 24'h0);
    check("R10 update edge", {63'd0, hs_out}, 64'd1);

    // Gated clock, single mode, R8
    cfg_two_pix = 0; cfg_gate_clk = 1;
    step(0, 0, 0, 3'b000, 24'h0);
    check("R8 gated low hi", {63'd0, oclk}, 64'd0);
    @(negedge clk); #1;
    check("R8 gated low lo", {63'd0, oclk}, 64'd0);
    step(1, 0, 0, 3'b000, 24'h111111);
    check("R8 gated run hi", {63'd0, oclk}, 64'd0);
    @(negedge clk); #1;
    check("R8 gated run lo", {63'd0, oclk}, 64'd1);

    // Falling polarity, R7
    cfg_gate_clk = 0; cfg_rise_pol = 0;
    step(0, 0, 0, 3'b000, 24'h0);
    check("R7 fall pol hi", {63'd0, oclk}, 64'd1);
    @(negedge clk); #1;
    check("R7 fall pol lo", {63'd0, oclk}, 64'd0);

    // Power-down, R9
    pwr_dn = 1;
    step(1, 1, 1, 3'b111, 24'hFFFFFF);
    check("R9 pd pixel", {40'd0, q_even}, 64'd0);
    check("R9 pd de/hs/vs/ctl", {58'd0, de_out, hs_out, vs_out, ctl_out}, 64'd1);
    check("R9 pd oclk hi", {63'd0, oclk}, 64'd0);
    @(negedge clk); #1;
    check("R9 pd oclk lo", {63'd0, oclk}, 64'd0);
    step(1, 1, 1, 3'b110, 24'hFFFFFF);
    check("R9 ctl1 follows", {61'd0, ctl_out}, 64'd0);
    pwr_dn = 0;

    // Reset mid-stream, R1
    step(1, 1, 1, 3'b111, 24'h424242);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 mid reset even", {40'd0, q_even}, 64'd0);
    check("R1 mid reset ctl", {58'd0, de_out, hs_out, vs_out, ctl_out}, 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule